// File: doc/BRIEF.md
# Timer Event Flag Logic

This block sits beside a 16-bit timer that has three capture/compare channels. It turns the timer's raw event strobes into sticky status flags: one per channel and one overflow flag. It also produces a masked CPU interrupt request and one DMA trigger pulse per channel. The counter, the comparators and the capture registers live elsewhere. This block only sees their one-cycle strobes and decides which strobe sets which flag.

The routing depends on the counting mode. Free-running and modulo counting use each channel's own event and the terminal-count strobe. Up/down counting uses the zero turnaround for overflow. When channel 0 is in compare mode during up/down counting, the turnaround also sets channel 0's flag. Software clears flags with write-one-to-clear strobes. The DMA triggers follow the channel events regardless of the masks.

All control pins are plain level or strobe signals. No data stream crosses this block, so there is no valid/ready handshake and no back-pressure.

Top module: `tmr_evt_flags`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, every flag output, `cpu_irq` and every `dma_trig` bit is 0.
- R2: In `count_mode` 2'b00 (free-running) or 2'b01 (modulo), `ch_flag[i]` is set at the clock edge where channel i's event is high. The channel's event is `cap_evt[i]` when `ch_capture[i]`=1 and `cmp_evt[i]` when it is 0. The strobe that does not match the channel setting is ignored.
- R3: In modes 2'b00 and 2'b01, `ovf_flag` is set by `tc_evt`, and `zero_evt` has no effect.
- R4: In `count_mode` 2'b10 (up/down), when `ch_capture[0]`=0, `ch_flag[0]` is set by `zero_evt`, and `cmp_evt[0]` does not set it.
- R5: In mode 2'b10, `ovf_flag` is set by `zero_evt`, and `tc_evt` has no effect.
- R6: In mode 2'b10, channels 1 and 2 are set by their own events. Channel 0 is set by `cap_evt[0]` when `ch_capture[0]`=1, and a turnaround then leaves it unchanged.
- R7: In `count_mode` 2'b11 (halted), no strobe sets any flag.
- R8: A flag stays set until its clear strobe (`ch_clr[i]` or `ovf_clr`) is high at a clock edge. A set event and a clear at the same edge leave the flag set.
- R9: `cpu_irq` is a register that holds, one cycle later, the OR of `ovf_flag` with every `ch_flag[i]` whose `ch_irq_mask[i]` is 1.
- R10: `dma_trig[i]` is high for exactly the one cycle after channel i's event. This holds in every mode and does not depend on the masks or the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_mode | input | 2 | 00 free-running, 01 modulo, 10 up/down, 11 halted |
| ch_capture | input | 3 | Per channel: 1 capture, 0 compare |
| cmp_evt | input | 3 | Per-channel compare strobe |
| cap_evt | input | 3 | Per-channel capture strobe |
| tc_evt | input | 1 | Counter reached terminal count |
| zero_evt | input | 1 | Counter turned around at zero |
| ch_clr | input | 3 | Write-one-to-clear strobes for the channel flags |
| ovf_clr | input | 1 | Write-one-to-clear strobe for the overflow flag |
| ch_irq_mask | input | 3 | Per-channel interrupt enable |
| ch_flag | output | 3 | Sticky channel flags |
| ovf_flag | output | 1 | Sticky overflow flag |
| cpu_irq | output | 1 | Registered combined interrupt request |
| dma_trig | output | 3 | One-cycle DMA trigger per channel |

## Verification
The assertions check on every cycle that flags are sticky and that the interrupt register tracks the masked flags one cycle late. They also check that each DMA pulse mirrors the selected channel event, that halted mode sets nothing, and that the terminal-count and turnaround strobes set overflow in their own modes. Only the bench's scenarios can show the mode-dependent routing of channel 0: whether the turnaround or the compare strobe sets it, and which strobe is ignored for a given capture setting. The scenarios also cover set-beats-clear priority and the reset values.

// File: rtl/tmr_evt_pkg.sv
package tmr_evt_pkg;
  localparam int NCH = 3;

  typedef enum logic [1:0] {
    CM_FREE = 2'b00,
    CM_MOD  = 2'b01,
    CM_UPDN = 2'b10,
    CM_HALT = 2'b11
  } cnt_mode_e;
endpackage

// File: rtl/tmr_evt_route.sv
// Decides, per counting mode, which strobe sets each flag.
module tmr_evt_route
  import tmr_evt_pkg::*;
#(
  parameter int NCH     = tmr_evt_pkg::NCH,
  parameter int TURN_CH = 0
) (
  input  cnt_mode_e          mode,
  input  logic [NCH-1:0]     ch_capture,
  input  logic [NCH-1:0]     cmp_evt,
  input  logic [NCH-1:0]     cap_evt,
  input  logic               tc_evt,
  input  logic               zero_evt,
  output logic [NCH-1:0]     chan_evt,
  output logic [NCH-1:0]     ch_set,
  output logic               ovf_set
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign chan_evt[i] = ch_capture[i] ? cap_evt[i] : cmp_evt[i];

    always_comb begin
      unique case (mode)
        CM_FREE, CM_MOD: ch_set[i] = chan_evt[i];
        CM_UPDN: begin
          if (i == TURN_CH && !ch_capture[i]) ch_set[i] = zero_evt;
          else                                ch_set[i] = chan_evt[i];
        end
        default:         ch_set[i] = 1'b0;
      endcase
    end
  end

  always_comb begin
    unique case (mode)
      CM_FREE, CM_MOD: ovf_set = tc_evt;
      CM_UPDN:         ovf_set = zero_evt;
      default:         ovf_set = 1'b0;
    endcase
  end
endmodule

// File: rtl/tmr_flag_bank.sv
// Sticky flags; a set at the same edge as a clear wins.
module tmr_flag_bank #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] flag
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag[i] <= 1'b0;
      else if (set[i]) flag[i] <= 1'b1;
      else if (clr[i]) flag[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_irq_dma.sv
// Registered interrupt combine and DMA pulse stage.
module tmr_irq_dma #(
  parameter int NCH = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] ch_flag,
  input  logic           ovf_flag,
  input  logic [NCH-1:0] mask,
  input  logic [NCH-1:0] chan_evt,
  output logic           cpu_irq,
  output logic [NCH-1:0] dma_trig
);
  logic irq_d;
  assign irq_d = (|(ch_flag & mask)) | ovf_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_irq  <= 1'b0;
      dma_trig <= '0;
    end else begin
      cpu_irq  <= irq_d;
      dma_trig <= chan_evt;
    end
  end
endmodule

// File: rtl/tmr_evt_flags.sv
module tmr_evt_flags
  import tmr_evt_pkg::*;
#(
  parameter int NCH = tmr_evt_pkg::NCH
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     count_mode,
  input  logic [NCH-1:0] ch_capture,
  input  logic [NCH-1:0] cmp_evt,
  input  logic [NCH-1:0] cap_evt,
  input  logic           tc_evt,
  input  logic           zero_evt,
  input  logic [NCH-1:0] ch_clr,
  input  logic           ovf_clr,
  input  logic [NCH-1:0] ch_irq_mask,
  output logic [NCH-1:0] ch_flag,
  output logic           ovf_flag,
  output logic           cpu_irq,
  output logic [NCH-1:0] dma_trig
);
  logic [NCH-1:0] chan_evt, ch_set;
  logic           ovf_set;

  tmr_evt_route #(.NCH(NCH), .TURN_CH(0)) u_route (
    .mode(cnt_mode_e'(count_mode)), .ch_capture(ch_capture),
    .cmp_evt(cmp_evt), .cap_evt(cap_evt), .tc_evt(tc_evt),
    .zero_evt(zero_evt), .chan_evt(chan_evt), .ch_set(ch_set),
    .ovf_set(ovf_set)
  );

  tmr_flag_bank #(.W(NCH)) u_ch_flags (
    .clk(clk), .rst_n(rst_n), .set(ch_set), .clr(ch_clr), .flag(ch_flag)
  );

  tmr_flag_bank #(.W(1)) u_ovf_flag (
    .clk(clk), .rst_n(rst_n), .set(ovf_set), .clr(ovf_clr), .flag(ovf_flag)
  );

  tmr_irq_dma #(.NCH(NCH)) u_out (
    .clk(clk), .rst_n(rst_n), .ch_flag(ch_flag), .ovf_flag(ovf_flag),
    .mask(ch_irq_mask), .chan_evt(chan_evt), .cpu_irq(cpu_irq),
    .dma_trig(dma_trig)
  );
endmodule

// File: rtl/tmr_evt_flags_chk.sv
module tmr_evt_flags_chk #(
  parameter int NCH = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic [1:0]     count_mode,
  input logic [NCH-1:0] ch_capture,
  input logic [NCH-1:0] cmp_evt,
  input logic [NCH-1:0] cap_evt,
  input logic           tc_evt,
  input logic           zero_evt,
  input logic [NCH-1:0] ch_clr,
  input logic           ovf_clr,
  input logic [NCH-1:0] ch_irq_mask,
  input logic [NCH-1:0] ch_flag,
  input logic           ovf_flag,
  input logic           cpu_irq,
  input logic [NCH-1:0] dma_trig
);
  logic [NCH-1:0] sel_evt;
  assign sel_evt = (ch_capture & cap_evt) | (~ch_capture & cmp_evt);

  AST_CH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_flag & ~ch_clr) != '0 |=> (ch_flag & $past(ch_flag & ~ch_clr)) == $past(ch_flag & ~ch_clr)); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag && !ovf_clr |=> ovf_flag); // R8
  AST_IRQ_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cpu_irq == $past((|(ch_flag & ch_irq_mask)) | ovf_flag)); // R9
  AST_DMA_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> dma_trig == $past(sel_evt)); // R10
  AST_HALT_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    count_mode == 2'b11 |=> ((ch_flag & ~$past(ch_flag)) == '0) && !(ovf_flag && !$past(ovf_flag))); // R7
  AST_TC_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    count_mode < 2'b10 && tc_evt |=> ovf_flag); // R3
  AST_ZERO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    count_mode == 2'b10 && zero_evt |=> ovf_flag); // R5
endmodule

bind tmr_evt_flags tmr_evt_flags_chk #(.NCH(NCH)) u_chk (.*);

// File: tb/tmr_evt_flags_bench.sv
module tmr_evt_flags_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] count_mode = 2'b00;
  logic [2:0] ch_capture = '0, cmp_evt = '0, cap_evt = '0, ch_clr = '0, ch_irq_mask = '0;
  logic       tc_evt = 1'b0, zero_evt = 1'b0, ovf_clr = 1'b0;
  logic [2:0] ch_flag, dma_trig;
  logic       ovf_flag, cpu_irq;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_evt_flags u_tmr_evt_flags (
    .clk(clk), .rst_n(rst_n), .count_mode(count_mode), .ch_capture(ch_capture),
    .cmp_evt(cmp_evt), .cap_evt(cap_evt), .tc_evt(tc_evt), .zero_evt(zero_evt),
    .ch_clr(ch_clr), .ovf_clr(ovf_clr), .ch_irq_mask(ch_irq_mask),
    .ch_flag(ch_flag), .ovf_flag(ovf_flag), .cpu_irq(cpu_irq), .dma_trig(dma_trig)
  );

  task automatic chk(string req, string what, logic [2:0] act, logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // Drive strobes for one edge, then drop them; outputs are sampled after.
  task automatic pulse(logic [2:0] cmp, logic [2:0] cap, logic tc, logic zr,
                       logic [2:0] cc, logic oc);
    cmp_evt = cmp; cap_evt = cap; tc_evt = tc; zero_evt = zr; ch_clr = cc; ovf_clr = oc;
    @(negedge clk);
    cmp_evt = '0; cap_evt = '0; tc_evt = 1'b0; zero_evt = 1'b0; ch_clr = '0; ovf_clr = 1'b0;
  endtask

  task automatic clear_all();
    pulse(3'b000, 3'b000, 1'b0, 1'b0, 3'b111, 1'b1);
  endtask

  task automatic t_reset();
    chk("R1", "ch_flag", ch_flag, 3'b000);
    chk("R1", "ovf_flag", {2'b0, ovf_flag}, 3'b000);
    chk("R1", "cpu_irq", {2'b0, cpu_irq}, 3'b000);
    chk("R1", "dma_trig", dma_trig, 3'b000);
  endtask

  task automatic t_free_channels();
    count_mode = 2'b00; ch_capture = 3'b010;
    pulse(3'b111, 3'b000, 1'b0, 1'b0, 3'b000, 1'b0);
    chk("R2", "compare strobes", ch_flag, 3'b101);
    chk("R10", "dma on compare", dma_trig, 3'b101);
    @(negedge clk);
    chk("R10", "dma single cycle", dma_trig, 3'b000);
    clear_all();
    pulse(3'b000, 3'b111, 1'b0, 1'b0, 3'b000, 1'b0);
    chk("R2", "capture strobes", ch_flag, 3'b010);
    clear_all();
  endtask

  task automatic t_modulo_ovf();
    count_mode = 2'b01;
    pulse(3'b000, 3'b000, 1'b0, 1'b1, 3'b000, 1'b0);
    chk("R3", "zero ignored", {2'b0, ovf_flag}, 3'b000);
    pulse(3'b000, 3'b000, 1'b1, 1'b0, 3'b000, 1'b0);
    chk("R3", "tc sets ovf", {2'b0, ovf_flag}, 3'b001);
    clear_all();
  endtask

  task automatic t_updn_compare();
    count_mode = 2'b10; ch_capture = 3'b000;
    pulse(3'b001, 3'b000, 1'b0, 1'b0, 3'b000, 1'b0);
    chk("R4", "ch0 compare ignored", ch_flag, 3'b000);
    chk("R10", "dma ch0 in updown", dma_trig, 3'b001);
    pulse(3'b000, 3'b000, 1'b0, 1'b1, 3'b000, 1'b0);
    chk("R4", "turnaround sets ch0", ch_flag, 3'b001);
    chk("R5", "turnaround sets ovf", {2'b0, ovf_flag}, 3'b001);
    clear_all();
    pulse(3'b000, 3'b000, 1'b1, 1'b0, 3'b000, 1'b0);
    chk("R5", "tc ignored", {2'b0, ovf_flag}, 3'b000);
    pulse(3'b110, 3'b000, 1'b0, 1'b0, 3'b000, 1'b0);
    chk("R6", "ch1 ch2 compare", ch_flag, 3'b110);
    clear_all();
  endtask

  task automatic t_updn_capture();
    count_mode = 2'b10; ch_capture = 3'b111;
    pulse(3'b000, 3'b000, 1'b0, 1'b1, 3'b000, 1'b0);
    chk("R6", "ch0 capture ignores turn", ch_flag, 3'b000);
    chk("R5", "ovf on turn", {2'b0, ovf_flag}, 3'b001);
    pulse(3'b000, 3'b101, 1'b0, 1'b0, 3'b000, 1'b0);
    chk("R6", "capture events", ch_flag, 3'b101);
    clear_all();
  endtask

  task automatic t_halt();
    count_mode = 2'b11; ch_capture = 3'b100;
    pulse(3'b011, 3'b100, 1'b1, 1'b1, 3'b000, 1'b0);
    chk("R7", "no channel set", ch_flag, 3'b000);
    chk("R7", "no ovf set", {2'b0, ovf_flag}, 3'b000);
    chk("R10", "dma in halt", dma_trig, 3'b111);
  endtask

  task automatic t_sticky();
    count_mode = 2'b00; ch_capture = 3'b000;
    pulse(3'b011, 3'b000, 1'b0, 1'b0, 3'b000, 1'b0);
    @(negedge clk); @(negedge clk);
    chk("R8", "flags held", ch_flag, 3'b011);
    pulse(3'b000, 3'b000, 1'b0, 1'b0, 3'b001, 1'b0);
    chk("R8", "w1c ch0", ch_flag, 3'b010);
    pulse(3'b100, 3'b000, 1'b1, 1'b0, 3'b100, 1'b1);
    chk("R8", "set beats clear ch2", ch_flag, 3'b110);
    chk("R8", "set beats clear ovf", {2'b0, ovf_flag}, 3'b001);
    clear_all();
    chk("R8", "all cleared", {ch_flag[2:1], ovf_flag}, 3'b000);
  endtask

  task automatic t_irq();
    count_mode = 2'b00; ch_capture = 3'b000; ch_irq_mask = 3'b000;
    @(negedge clk);
    pulse(3'b001, 3'b000, 1'b0, 1'b0, 3'b000, 1'b0);
    chk("R9", "irq lags flag", {2'b0, cpu_irq}, 3'b000);
    @(negedge clk);
    chk("R9", "masked off", {2'b0, cpu_irq}, 3'b000);
    ch_irq_mask = 3'b001;
    @(negedge clk);
    chk("R9", "mask on", {2'b0, cpu_irq}, 3'b001);
    ch_irq_mask = 3'b110;
    @(negedge clk);
    chk("R9", "other masks", {2'b0, cpu_irq}, 3'b000);
    clear_all();
    ch_irq_mask = 3'b000;
    pulse(3'b000, 3'b000, 1'b1, 1'b0, 3'b000, 1'b0);
    @(negedge clk);
    chk("R9", "ovf unmasked", {2'b0, cpu_irq}, 3'b001);
    clear_all();
    @(negedge clk);
    chk("R9", "irq drops", {2'b0, cpu_irq}, 3'b000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_free_channels();
    t_modulo_ovf();
    t_updn_compare();
    t_updn_capture();
    t_halt();
    t_sticky();
    t_irq();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog all-reqs actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule